// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a processor core clock from one divisor to another without breaking DRAM refresh. A host offers a target divisor index (0..4 for divide-by 1, 2, 4, 6 or 8). The sequencer then runs an ordered list of register writes. The writes touch three things: the 3-bit divider mode code, the 7-bit refresh count and the memory self-refresh enable. Between writes it waits for the PLL to relock, and it waits for outstanding refresh counts to drain. The PLL, the memory controller and the clock source sit outside. They see only the three register values that this block drives.

The request side is a valid/ready pair. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the transition finishes, so the host may hold or drop `req_valid` freely. Anything offered while ready is low is simply not taken. Completion is reported by a one-cycle `done` pulse. A rejected index is reported by a one-cycle `err` pulse.

In the memory control word, the refresh count sits at bits 14:8 and the self-refresh enable at bit 16. This block drives those fields as separate outputs. Each refresh count unit stands for 64 clocks.

Top module: `clkdiv_seq`

## Requirements
- R1: The divider mode output uses the codes ÷1=000, ÷2=001, ÷4=011, ÷6=010, ÷8=100 for indices 0..4, and never shows any other code. A request with index 5, 6 or 7 produces a one-cycle `err` pulse on the accepting edge, and nothing else changes.
- R2: After reset the divider mode is 000, self-refresh enable is 0, the refresh count holds the ÷1 value, `req_ready` is 1, and `done` and `err` are 0.
- R3: `req_ready` is high only while idle. Requests offered while it is low are ignored. `done` pulses for one cycle together with the final step when that step has no wait, or on the last cycle of that step's wait.
- R4: A change from ÷1 to ÷4/÷6/÷8, or from any of those to ÷1, runs as two legs through ÷2. Each leg follows its own ordering rule.
- R5: ÷2→÷1 clears self-refresh enable first, then writes the divider code, then writes the refresh count.
- R6: ÷1→÷2 writes the refresh count first, then the divider code, then sets self-refresh enable.
- R7: Any other increase of the divisor writes the refresh count before the divider code. Any other decrease writes the divider code before the refresh count.
- R8: After a divider code write, the next step happens exactly LOCK_CYCLES+1 cycles later (17 with defaults), never earlier than LOCK_CYCLES. Steps without a wait follow one cycle apart.
- R9: The refresh count for divisor d is floor(BASE_MHZ·7800/(64000·d)): 60, 30, 15, 10, 7 for the default 500 MHz base.
- R10: A refresh count write made while slowing, with self-refresh off, is followed by a wait of 64·(old count + new count)·(old divisor) cycles before the next step (5760 cycles for ÷1→÷2 at defaults).
- R11: A legal request for the current divisor gives `done` on the accepting edge, and no output field changes.
- R12: Self-refresh enable changes only while the divider code is ÷1 or ÷2. Whenever idle, it equals 1 exactly when the divisor is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_idx | input | 3 | Target divisor index (0..4 legal) |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| done | output | 1 | One-cycle pulse: transition complete |
| err | output | 1 | One-cycle pulse: illegal index rejected |
| div_mode | output | 3 | Divider mode code to the clock generator |
| refr_cnt | output | 7 | Refresh count field (memory control bits 14:8) |
| sref_en | output | 1 | Self-refresh enable (memory control bit 16) |

## Verification
Some properties are checked on every cycle by assertions. The divider code is always legal. The code never jumps between ÷1 and a divisor above 2. No field changes within LOCK_CYCLES of a divider write. Self-refresh toggles only at the ÷1/÷2 boundary and matches the divisor when idle. An error pulse leaves the divider untouched. Other behaviour only the bench's scenarios can show. These are the exact order of writes for each kind of transition, the values of the refresh counts, the exact length of the drain wait, the immediate completion of a same-divisor request, and the ignoring of requests made mid-transition.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int IDX_W   = 3;
  localparam int NUM_DIV = 5;

  typedef enum logic [2:0] {
    MODE_D1 = 3'b000,
    MODE_D2 = 3'b001,
    MODE_D6 = 3'b010,
    MODE_D4 = 3'b011,
    MODE_D8 = 3'b100
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DIV,
    OP_REFR,
    OP_SREF_ON,
    OP_SREF_OFF
  } op_e;

  function automatic int div_of(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [2:0] mode_of(input int idx);
    case (idx)
      0: return MODE_D1;
      1: return MODE_D2;
      2: return MODE_D4;
      3: return MODE_D6;
      4: return MODE_D8;
      default: return MODE_D1;
    endcase
  endfunction

  // refresh interval 7800 ns, 64 clocks per count unit
  function automatic int refr_calc(input int base_mhz, input int idx);
    return (base_mhz * 7800) / (64000 * div_of(idx));
  endfunction
endpackage

// File: rtl/clkdiv_codemap.sv
module clkdiv_codemap
  import clkdiv_pkg::*;
#(
  parameter int BASE_MHZ = 500,
  parameter int CNT_W    = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic             legal,
  output logic [2:0]       mode,
  output logic [CNT_W-1:0] cnt,
  output logic [3:0]       dval
);
  logic [CNT_W-1:0] rc_tab [NUM_DIV];
  logic [2:0]       md_tab [NUM_DIV];
  logic [3:0]       dv_tab [NUM_DIV];

  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_tab
    localparam int RC = refr_calc(BASE_MHZ, gi);
    localparam int DV = div_of(gi);
    assign rc_tab[gi] = CNT_W'(RC);
    assign md_tab[gi] = mode_of(gi);
    assign dv_tab[gi] = 4'(DV);
  end

  always_comb begin
    legal = 1'b1;
    mode  = md_tab[0];
    cnt   = rc_tab[0];
    dval  = dv_tab[0];
    case (idx)
      3'd0: begin mode = md_tab[0]; cnt = rc_tab[0]; dval = dv_tab[0]; end
      3'd1: begin mode = md_tab[1]; cnt = rc_tab[1]; dval = dv_tab[1]; end
      3'd2: begin mode = md_tab[2]; cnt = rc_tab[2]; dval = dv_tab[2]; end
      3'd3: begin mode = md_tab[3]; cnt = rc_tab[3]; dval = dv_tab[3]; end
      3'd4: begin mode = md_tab[4]; cnt = rc_tab[4]; dval = dv_tab[4]; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/clkdiv_legplan.sv
module clkdiv_legplan
  import clkdiv_pkg::*;
(
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic [1:0]       step,
  output op_e              op,
  output logic [1:0]       nops
);
  always_comb begin
    if (src == 3'd1 && dst == 3'd0) begin
      // speeding into divide-1: leave self-refresh first
      nops = 2'd3;
      case (step)
        2'd0:    op = OP_SREF_OFF;
        2'd1:    op = OP_DIV;
        default: op = OP_REFR;
      endcase
    end else if (src == 3'd0 && dst == 3'd1) begin
      // slowing out of divide-1: refresh first, self-refresh last
      nops = 2'd3;
      case (step)
        2'd0:    op = OP_REFR;
        2'd1:    op = OP_DIV;
        default: op = OP_SREF_ON;
      endcase
    end else if (dst > src) begin
      nops = 2'd2;
      op   = (step == 2'd0) ? OP_REFR : OP_DIV;
    end else begin
      nops = 2'd2;
      op   = (step == 2'd0) ? OP_DIV : OP_REFR;
    end
  end
endmodule

// File: rtl/clkdiv_timer.sv
module clkdiv_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int BASE_MHZ    = 500,
  parameter int CNT_W       = 7,
  parameter int LOCK_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  output logic [2:0]       div_mode,
  output logic [CNT_W-1:0] refr_cnt,
  output logic             sref_en
);
  localparam int TMR_W = CNT_W + 11;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT} st_e;

  st_e              state;
  logic [IDX_W-1:0] cur_idx, leg_src, leg_dst, tgt_idx;
  logic [1:0]       step;

  logic             req_legal;
  logic [2:0]       req_mode_unused;
  logic [CNT_W-1:0] req_cnt_unused;
  logic [3:0]       req_dval_unused;
  logic             dst_legal_unused, src_legal_unused;
  logic [2:0]       dst_mode, src_mode_unused;
  logic [CNT_W-1:0] dst_cnt, src_cnt_unused;
  logic [3:0]       dst_dval_unused, src_dval;

  op_e              op;
  logic [1:0]       nops;
  logic [TMR_W-1:0] wait_len, drain_len;
  logic             tmr_last, tmr_load, adv, step_last, two_leg;

  clkdiv_codemap #(.BASE_MHZ(BASE_MHZ), .CNT_W(CNT_W)) u_map_req (
    .idx(req_idx), .legal(req_legal), .mode(req_mode_unused),
    .cnt(req_cnt_unused), .dval(req_dval_unused));

  clkdiv_codemap #(.BASE_MHZ(BASE_MHZ), .CNT_W(CNT_W)) u_map_dst (
    .idx(leg_dst), .legal(dst_legal_unused), .mode(dst_mode),
    .cnt(dst_cnt), .dval(dst_dval_unused));

  clkdiv_codemap #(.BASE_MHZ(BASE_MHZ), .CNT_W(CNT_W)) u_map_src (
    .idx(leg_src), .legal(src_legal_unused), .mode(src_mode_unused),
    .cnt(src_cnt_unused), .dval(src_dval));

  clkdiv_legplan u_plan (
    .src(leg_src), .dst(leg_dst), .step(step), .op(op), .nops(nops));

  clkdiv_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(wait_len),
    .last(tmr_last));

  // both counts must run out at the old clock rate
  assign drain_len = ((TMR_W'(refr_cnt) + TMR_W'(dst_cnt)) * TMR_W'(src_dval)) << 6;

  always_comb begin
    case (op)
      OP_DIV:  wait_len = TMR_W'(LOCK_CYCLES);
      OP_REFR: wait_len = (leg_dst > leg_src && !sref_en) ? drain_len : '0;
      default: wait_len = '0;
    endcase
  end

  assign tmr_load  = (state == ST_EXEC) && (wait_len != '0);
  assign adv       = ((state == ST_EXEC) && (wait_len == '0)) ||
                     ((state == ST_WAIT) && tmr_last);
  assign step_last = (step == nops - 2'd1);
  assign two_leg   = (cur_idx == 3'd0 && req_idx > 3'd1) ||
                     (cur_idx > 3'd1 && req_idx == 3'd0);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_idx  <= '0;
      leg_src  <= '0;
      leg_dst  <= '0;
      tgt_idx  <= '0;
      step     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      div_mode <= MODE_D1;
      refr_cnt <= CNT_W'(refr_calc(BASE_MHZ, 0));
      sref_en  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_legal) begin
              err <= 1'b1;
            end else if (req_idx == cur_idx) begin
              done <= 1'b1;
            end else begin
              tgt_idx <= req_idx;
              leg_src <= cur_idx;
              leg_dst <= two_leg ? 3'd1 : req_idx;
              step    <= '0;
              state   <= ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          case (op)
            OP_DIV: begin
              div_mode <= dst_mode;
              cur_idx  <= leg_dst;
            end
            OP_REFR:     refr_cnt <= dst_cnt;
            OP_SREF_ON:  sref_en  <= 1'b1;
            OP_SREF_OFF: sref_en  <= 1'b0;
            default: ;
          endcase
          if (!adv) state <= ST_WAIT;
        end
        default: ;
      endcase

      if (adv) begin
        if (!step_last) begin
          step  <= step + 2'd1;
          state <= ST_EXEC;
        end else if (leg_dst != tgt_idx) begin
          leg_src <= leg_dst;
          leg_dst <= tgt_idx;
          step    <= '0;
          state   <= ST_EXEC;
        end else begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic [2:0]       div_seen;
  logic [TMR_W-1:0] lock_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_seen <= MODE_D1;
      lock_age <= '1;
    end else begin
      div_seen <= div_mode;
      if (div_mode != div_seen)  lock_age <= TMR_W'(1);
      else if (lock_age != '1)   lock_age <= lock_age + 1'b1;
    end
  end

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode inside {MODE_D1, MODE_D2, MODE_D4, MODE_D6, MODE_D8});

  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (div_mode == $past(div_mode)));

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_via_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_mode != $past(div_mode)) && (div_mode == MODE_D1 || $past(div_mode) == MODE_D1))
      |-> (div_mode == MODE_D2 || $past(div_mode) == MODE_D2));

  assert_lock_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((refr_cnt != $past(refr_cnt)) || (sref_en != $past(sref_en)) ||
     (div_mode != $past(div_mode))) |-> (lock_age >= TMR_W'(LOCK_CYCLES)));

  assert_sref_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sref_en != $past(sref_en)) |-> (div_mode == MODE_D1 || div_mode == MODE_D2));

  assert_sref_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sref_en == (div_mode != MODE_D1)));
endmodule

// File: tb/sim_clkdiv_seq.sv
module sim_clkdiv_seq;
  localparam int LOCK = 16;
  localparam int BASE = 500;
  localparam int K_DIV = 0, K_REFR = 1, K_SREF = 2, K_DONE = 3, K_ERR = 4;

  typedef struct {
    int    kind;
    int    val;
    int    gap;
    string tag;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_idx = '0;
  logic       req_ready, done, err, sref_en;
  logic [2:0] div_mode;
  logic [6:0] refr_cnt;

  clkdiv_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_ready(req_ready), .done(done), .err(err), .div_mode(div_mode),
    .refr_cnt(refr_cnt), .sref_en(sref_en));

  always #10 clk = ~clk;

  ev_t q[$];
  int  checks = 0, fails = 0;
  int  cyc = 0, last_cyc = 0;
  int  cur_b = 0, cnt_b = 0, pend = -1;
  bit  sref_b = 0, finished = 0;
  logic [2:0] p_div;
  logic [6:0] p_refr;
  logic       p_sref;

  function automatic int dv(input int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic int code(input int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
  endfunction
  function automatic int rc(input int i);
    return (BASE * 7800) / (64000 * dv(i));
  endfunction

  task automatic push(input int k, input int v, input int g, input string t);
    ev_t e;
    e.kind = k; e.val = v; e.gap = g; e.tag = t;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic model_leg(input int s, input int d, input string lt);
    int w;
    if (s == 1 && d == 0) begin
      push(K_SREF, 0, pend, {lt, " R5 R12"}); pend = 1; sref_b = 0;
      push(K_DIV, code(0), pend, {lt, " R5 R1"}); pend = LOCK + 1;
      push(K_REFR, rc(0), pend, {lt, " R5 R8 R9"}); pend = 1; cnt_b = rc(0);
    end else if (s == 0 && d == 1) begin
      w = sref_b ? 0 : 64 * (cnt_b + rc(1)) * dv(0);
      push(K_REFR, rc(1), pend, {lt, " R6 R9"}); pend = w + 1; cnt_b = rc(1);
      push(K_DIV, code(1), pend, {lt, " R6 R10"}); pend = LOCK + 1;
      push(K_SREF, 1, pend, {lt, " R6 R8 R12"}); pend = 1; sref_b = 1;
    end else if (d > s) begin
      w = sref_b ? 0 : 64 * (cnt_b + rc(d)) * dv(s);
      push(K_REFR, rc(d), pend, {lt, " R7 R9"}); pend = w + 1; cnt_b = rc(d);
      push(K_DIV, code(d), pend, {lt, " R7 R1"}); pend = LOCK + 1;
    end else begin
      push(K_DIV, code(d), pend, {lt, " R7 R1"}); pend = LOCK + 1;
      push(K_REFR, rc(d), pend, {lt, " R7 R8 R9"}); pend = 1; cnt_b = rc(d);
    end
    cur_b = d;
  endtask

  task automatic expect_req(input int idx);
    if (idx > 4) begin
      push(K_ERR, 0, -1, "R1 illegal index");
    end else if (idx == cur_b) begin
      push(K_DONE, 0, -1, "R11 same divisor");
    end else begin
      pend = -1;
      if ((cur_b == 0 && idx > 1) || (cur_b > 1 && idx == 0)) begin
        model_leg(cur_b, 1, "R4 leg1");
        model_leg(1, idx, "R4 leg2");
      end else begin
        model_leg(cur_b, idx, "single");
      end
      push(K_DONE, 0, pend - 1, "R3 done");
    end
  endtask

  task automatic offer(input int idx);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (q.size() != 0 && !finished) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_req(input int idx);
    expect_req(idx);
    offer(idx);
    settle();
  endtask

  task automatic sb(input int k, input int v);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL R3 unexpected event kind %0d: actual %0d expected none", k, v);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.val != v || (e.gap >= 0 && cyc - last_cyc != e.gap)) begin
        fails++;
        $display("FAIL %s: actual kind %0d val %0d gap %0d expected kind %0d val %0d gap %0d",
                 e.tag, k, v, cyc - last_cyc, e.kind, e.val, e.gap);
      end
    end
    last_cyc = cyc;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (div_mode != p_div)  sb(K_DIV, int'(div_mode));
      if (refr_cnt != p_refr) sb(K_REFR, int'(refr_cnt));
      if (sref_en != p_sref)  sb(K_SREF, int'(sref_en));
      if (done)               sb(K_DONE, 0);
      if (err)                sb(K_ERR, 0);
    end
    p_div  = div_mode;
    p_refr = refr_cnt;
    p_sref = sref_en;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(div_mode == 3'b000, "R2 div_mode", int'(div_mode), 0);
    check(refr_cnt == 7'd60,  "R2 R9 refr_cnt", int'(refr_cnt), 60);
    check(sref_en == 1'b0,    "R2 sref_en", int'(sref_en), 0);
    check(req_ready == 1'b1,  "R2 req_ready", int'(req_ready), 1);
    check(done == 1'b0 && err == 1'b0, "R2 done/err", int'(done | err), 0);
    cnt_b = rc(0);

    // divide 1 -> 2, with requests offered mid-transition (R3, R10)
    expect_req(1);
    offer(1);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      req_valid = 1'b1;
      req_idx   = 3'd3;
      check(req_ready == 1'b0, "R3 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    settle();

    run_req(0);   // 2 -> 1 (R5)
    run_req(1);   // 1 -> 2 (R6)
    run_req(2);   // 2 -> 4 up (R7)
    run_req(3);   // 4 -> 6 up
    run_req(4);   // 6 -> 8 up
    run_req(2);   // 8 -> 4 down
    run_req(4);   // 4 -> 8 up
    run_req(0);   // 8 -> 1 two legs (R4)
    run_req(3);   // 1 -> 6 two legs (R4)
    run_req(3);   // same divisor (R11)
    check(div_mode == 3'b010, "R11 div unchanged", int'(div_mode), 2);
    run_req(5);   // illegal (R1)
    run_req(7);   // illegal (R1)
    check(div_mode == 3'b010 && refr_cnt == 7'd10, "R1 no change after err",
          int'(refr_cnt), 10);
    run_req(1);   // 6 -> 2 down
    run_req(0);   // 2 -> 1
    check(sref_en == 1'b0 && refr_cnt == 7'd60, "R12 idle at divide-1",
          int'(sref_en), 0);
    check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule